// File: doc/BRIEF.md
# Bank-Balanced Weight Pruner and Encoder

This block takes a dense weight row, one signed element per accepted beat, and divides it into equal-width banks. Inside each bank it keeps only the `KEEP` weights with the largest magnitude and drops the rest. Every bank therefore ends up with the same number of nonzeros, whatever the data. The kept weights leave the block as a stream of groups. Group `g` has one lane per bank, and each lane carries the `g`-th survivor of its bank together with that survivor's position inside the bank. A downstream engine can use the position directly as a local memory address and can work on all banks in parallel.

Rows are handled one after another in the same way. While a row's groups are being sent out, the intake side holds its ready low. Row width, bank count, keep count and element width are parameters. The row width must be an exact multiple of the bank count, and `KEEP` must not exceed the bank width.

Top module: `bbp_top`

## Requirements
- R1: Elements are taken on cycles where `in_valid` and `in_ready` are both high. The k-th accepted element of a row (counting from 0) belongs to bank k / BANK_W and has in-bank index k % BANK_W, where BANK_W = ROW_W / NBANK. Emission of the row begins on the cycle after its ROW_W-th element is taken.
- R2: In each bank, exactly KEEP elements are kept: those with the largest magnitude |x|, where x is a two's complement value and the most negative code has magnitude 2^(DW-1).
- R3: Lane b of an output group occupies `out_val[b*DW +: DW]` and `out_idx[b*IW +: IW]`, with IW = max(1, clog2(BANK_W)). It always describes bank b, and the index is the in-bank position (0..BANK_W-1), never the column in the full row.
- R4: Within a bank, survivors are sent in ascending in-bank index order, so group g carries the g-th lowest-indexed survivor of each bank.
- R5: Each row produces exactly KEEP groups. `out_grp` reads 0, 1, ..., KEEP-1 in turn, and `out_last` is high only on group KEEP-1.
- R6: When magnitudes are equal, the element with the lower in-bank index is kept.
- R7: `in_ready` is low on every cycle that `out_valid` is high. Elements offered on those cycles are not taken and do not affect any row. `in_ready` is high whenever no group is pending.
- R8: While `out_valid` is high and `out_ready` is low, the group on the outputs stays unchanged.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: Emitted values are the original signed weights, unaltered, including their sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input element is offered |
| in_ready | output | 1 | Block can accept an element |
| in_data | input | DW | Signed weight element |
| out_valid | output | 1 | A group is on the outputs |
| out_ready | input | 1 | Consumer takes the group |
| out_val | output | NBANK*DW | One kept weight per bank, bank 0 in the low lane |
| out_idx | output | NBANK*IW | In-bank index of each lane's weight |
| out_grp | output | GW | Group number within the row |
| out_last | output | 1 | Final group of the row |

## Verification
The assertions assume that `out_ready` and `in_valid` are ordinary handshake inputs that may change on any cycle, and that the consumer never needs a group repeated. They also assume that no intake can take place during emission, because ready is low then. The bench stays within these limits and still probes them hard. It offers junk elements with `in_valid` high during emission on alternate rows, stalls `out_ready` on selected groups, and leaves gaps in the input stream. It then checks every group of every row against a selection that it computes itself, by repeatedly picking the strict maximum.

// File: rtl/bbp_pkg.sv
package bbp_pkg;
  typedef enum logic {PH_FILL = 1'b0, PH_EMIT = 1'b1} phase_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bbp_row_buf.sv
module bbp_row_buf #(
  parameter int ROW_W = 16,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [DW-1:0]       din,
  output logic [ROW_W*DW-1:0] row_q,
  output logic                row_done
);
  localparam int CW = bbp_pkg::idx_width(ROW_W);

  logic [CW-1:0] fill_q;

  assign row_done = take && (fill_q == CW'(ROW_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
      row_q  <= '0;
    end else if (take) begin
      row_q[int'(fill_q)*DW +: DW] <= din;
      fill_q <= row_done ? '0 : fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/bbp_bank_select.sv
module bbp_bank_select #(
  parameter int BANK_W = 4,
  parameter int KEEP   = 2,
  parameter int DW     = 8,
  parameter int IW     = 2
) (
  input  logic [BANK_W*DW-1:0] bank_vals,
  output logic [KEEP*DW-1:0]   sel_vals,
  output logic [KEEP*IW-1:0]   sel_idx
);
  // magnitude of a two's complement value, one bit wider so -2^(DW-1) fits
  function automatic logic [DW:0] mag_of(input logic [DW-1:0] v);
    return v[DW-1] ? ({1'b0, ~v} + 1'b1) : {1'b0, v};
  endfunction

  // strict ordering: bigger magnitude first, lower index on a tie
  function automatic logic outranks(input logic [DW:0] ma, input int ia,
                                    input logic [DW:0] mb, input int ib);
    return (ma > mb) || ((ma == mb) && (ia < ib));
  endfunction

  logic [DW:0]       mags [BANK_W];
  logic [BANK_W-1:0] keep;

  always_comb begin
    for (int i = 0; i < BANK_W; i++) mags[i] = mag_of(bank_vals[i*DW +: DW]);
    for (int i = 0; i < BANK_W; i++) begin
      int rank;
      rank = 0;
      for (int j = 0; j < BANK_W; j++)
        if (j != i && outranks(mags[j], j, mags[i], i)) rank++;
      keep[i] = (rank < KEEP);
    end
  end

  always_comb begin
    int cnt;
    cnt      = 0;
    sel_vals = '0;
    sel_idx  = '0;
    for (int i = 0; i < BANK_W; i++) begin
      if (keep[i]) begin
        for (int g = 0; g < KEEP; g++) begin
          if (cnt == g) begin
            sel_vals[g*DW +: DW] = bank_vals[i*DW +: DW];
            sel_idx[g*IW +: IW]  = IW'(i);
          end
        end
        cnt++;
      end
    end
  end
endmodule

// File: rtl/bbp_group_emit.sv
module bbp_group_emit #(
  parameter int KEEP = 2,
  parameter int GW   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          row_done,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          in_ready,
  output logic [GW-1:0] grp,
  output logic          last,
  output logic          grp_adv
);
  import bbp_pkg::*;

  phase_e        phase_q;
  logic [GW-1:0] grp_q;

  assign out_valid = (phase_q == PH_EMIT);
  assign in_ready  = (phase_q == PH_FILL);
  assign grp       = grp_q;
  assign last      = out_valid && (grp_q == GW'(KEEP - 1));
  assign grp_adv   = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_FILL;
      grp_q   <= '0;
    end else if (phase_q == PH_FILL) begin
      if (row_done) begin
        phase_q <= PH_EMIT;
        grp_q   <= '0;
      end
    end else if (grp_adv) begin
      if (last) begin
        phase_q <= PH_FILL;
        grp_q   <= '0;
      end else begin
        grp_q <= grp_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bbp_top.sv
module bbp_top #(
  parameter int ROW_W = 16,
  parameter int NBANK = 4,
  parameter int KEEP  = 2,
  parameter int DW    = 8,
  localparam int BANK_W = ROW_W / NBANK,
  localparam int IW     = bbp_pkg::idx_width(BANK_W),
  localparam int GW     = bbp_pkg::idx_width(KEEP)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DW-1:0]       in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [NBANK*DW-1:0] out_val,
  output logic [NBANK*IW-1:0] out_idx,
  output logic [GW-1:0]       out_grp,
  output logic                out_last
);
  logic                fill_take;
  logic                row_done;
  logic                grp_adv;
  logic [ROW_W*DW-1:0] row_q;
  logic [KEEP*DW-1:0]  sel_v [NBANK];
  logic [KEEP*IW-1:0]  sel_i [NBANK];

  assign fill_take = in_valid && in_ready;

  bbp_row_buf #(.ROW_W(ROW_W), .DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .take(fill_take), .din(in_data),
    .row_q(row_q), .row_done(row_done)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bbp_bank_select #(.BANK_W(BANK_W), .KEEP(KEEP), .DW(DW), .IW(IW)) u_sel (
      .bank_vals(row_q[b*BANK_W*DW +: BANK_W*DW]),
      .sel_vals(sel_v[b]), .sel_idx(sel_i[b])
    );
  end

  bbp_group_emit #(.KEEP(KEEP), .GW(GW)) u_emit (
    .clk(clk), .rst_n(rst_n), .row_done(row_done), .out_ready(out_ready),
    .out_valid(out_valid), .in_ready(in_ready), .grp(out_grp),
    .last(out_last), .grp_adv(grp_adv)
  );

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      out_val[b*DW +: DW] = sel_v[b][int'(out_grp)*DW +: DW];
      out_idx[b*IW +: IW] = sel_i[b][int'(out_grp)*IW +: IW];
    end
  end
endmodule

// File: rtl/bbp_checker.sv
module bbp_checker #(
  parameter int NBANK  = 4,
  parameter int KEEP   = 2,
  parameter int DW     = 8,
  parameter int BANK_W = 4,
  parameter int IW     = 2,
  parameter int GW     = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [NBANK*DW-1:0] out_val,
  input logic [NBANK*IW-1:0] out_idx,
  input logic [GW-1:0]       out_grp,
  input logic                out_last,
  input logic                row_done
);
  p_ready_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |=> (out_valid && out_grp == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_val) && $stable(out_idx) && $stable(out_grp)));

  p_grp_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_grp) < KEEP));

  p_grp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=>
      (out_valid && out_grp == $past(out_grp) + 1'b1));

  p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  for (genvar b = 0; b < NBANK; b++) begin : g_lane
    p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_idx[b*IW +: IW]) < BANK_W));

    p_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !out_last) |=>
        (out_idx[b*IW +: IW] > $past(out_idx[b*IW +: IW])));
  end
endmodule

bind bbp_top bbp_checker #(
  .NBANK(NBANK), .KEEP(KEEP), .DW(DW), .BANK_W(BANK_W), .IW(IW), .GW(GW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_val(out_val), .out_idx(out_idx),
  .out_grp(out_grp), .out_last(out_last), .row_done(row_done)
);

// File: tb/tb_bbp_top.sv
module tb_bbp_top;
  localparam int ROW_W  = 12;
  localparam int NBANK  = 3;
  localparam int KEEP   = 2;
  localparam int DW     = 4;
  localparam int BANK_W = ROW_W / NBANK;
  localparam int IW     = 2;
  localparam int GW     = 1;
  localparam int NROWS  = 80;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [DW-1:0]       in_data = '0;
  logic                out_valid;
  logic                out_ready = 1'b0;
  logic [NBANK*DW-1:0] out_val;
  logic [NBANK*IW-1:0] out_idx;
  logic [GW-1:0]       out_grp;
  logic                out_last;

  int n_tests = 0;
  int n_fail  = 0;
  int row [ROW_W];
  int lcg = 32'h1234_5678;

  always #5 clk = ~clk;

  bbp_top #(.ROW_W(ROW_W), .NBANK(NBANK), .KEEP(KEEP), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_val(out_val), .out_idx(out_idx), .out_grp(out_grp), .out_last(out_last)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int absval(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // expected survivor list of a bank, ascending in-bank index
  task automatic expect_bank(input int b, output int idx_list [KEEP]);
    bit taken [BANK_W];
    int n;
    for (int i = 0; i < BANK_W; i++) taken[i] = 1'b0;
    for (int t = 0; t < KEEP; t++) begin
      int best;
      best = -1;
      for (int i = 0; i < BANK_W; i++)
        if (!taken[i] && (best < 0 || absval(row[b*BANK_W+i]) > absval(row[b*BANK_W+best])))
          best = i;
      taken[best] = 1'b1;
    end
    n = 0;
    for (int i = 0; i < BANK_W; i++)
      if (taken[i]) begin idx_list[n] = i; n++; end
  endtask

  task automatic make_row(input int r);
    for (int k = 0; k < ROW_W; k++) begin
      case (r)
        0: row[k] = 0;
        1: row[k] = 3;
        2: row[k] = (k % 2 == 0) ? -8 : 7;
        3: row[k] = 7 - k;
        4: row[k] = ((k % BANK_W) == BANK_W - 1) ? -5 : 5;
        default: begin
          lcg = lcg * 1103515245 + 12345;
          row[k] = int'((lcg >>> 16) & 15) - 8;
        end
      endcase
    end
  endtask

  // starts and ends at a negative edge
  task automatic send_row(input int r);
    for (int k = 0; k < ROW_W; k++) begin
      if ((r + k) % 5 == 0) begin
        in_valid = 1'b0;
        @(posedge clk); @(negedge clk);
      end
      check("R7 ready during fill", int'(in_ready), 1);
      check("R1 no output during fill", int'(out_valid), 0);
      in_valid = 1'b1;
      in_data  = DW'(row[k]);
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic collect_row(input int r);
    int exp_idx [NBANK][KEEP];
    for (int b = 0; b < NBANK; b++) expect_bank(b, exp_idx[b]);
    // junk offered during emission must be ignored (R7)
    in_valid = (r % 2 == 1);
    in_data  = DW'(r);
    for (int g = 0; g < KEEP; g++) begin
      if ((r + g) % 3 == 0) begin
        out_ready = 1'b0;
        check("R7 ready low while emitting", int'(in_ready), 0);
        check("R1 emission started", int'(out_valid), 1);
        @(posedge clk); @(negedge clk);
      end
      check("R7 ready low while emitting", int'(in_ready), 0);
      check("R8 group held valid", int'(out_valid), 1);
      check("R5 group number", int'(out_grp), g);
      check("R5 last flag", int'(out_last), int'(g == KEEP - 1));
      for (int b = 0; b < NBANK; b++) begin
        int ei, ev;
        ei = exp_idx[b][g];
        ev = row[b*BANK_W + ei];
        check("R2/R4/R6 in-bank index (R3 lane)", int'(out_idx[b*IW +: IW]), ei);
        check("R10 signed value", int'($signed(out_val[b*DW +: DW])), ev);
      end
      out_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      out_ready = 1'b0;
    end
    in_valid = 1'b0;
    check("R5 exactly KEEP groups", int'(out_valid), 0);
    check("R7 ready after emission", int'(in_ready), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset out_valid", int'(out_valid), 0);
    check("R9 reset in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int r = 0; r < NROWS; r++) begin
      make_row(r);
      send_row(r);
      collect_row(r);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule